// File: doc/BRIEF.md
# USB Supply Detect and Ready Sequencer

This block watches a digital "bus voltage present" level that an external comparator produces. It turns the level's edges into sticky attach and detach events. While the USB peripheral is enabled and the bus voltage is present, it drives the enable of the USB supply regulator. It then waits a fixed worst-case settling time before it reports that the regulator output is usable. Software must see this ready indication before it connects the D+ pull-up.

Software reads a status word and the sticky event flags through a simple register port, and clears the flags there. It also chooses which events raise the interrupt line. If the bus voltage appears while the chip is in its deepest power-off state, the block sends a one-cycle wake request to the reset controller. Along with the request it asserts the bus-voltage bit of the reset-cause vector. The analog regulator, the comparator and the USB device core sit outside this block.

Top module: `usb_supply_seq`

## Requirements
- R1: The bus-voltage input passes through a two-flop synchronizer. A change driven before clock edge k shows in status bit 0 after edge k+1, and not after edge k alone.
- R2: A rising edge of the synchronized level sets the attach flag (read at 0x11C, bit 0) one edge later. A falling edge sets the detach flag (0x120, bit 0) one edge later.
- R3: `reg_en` is high exactly while `usb_en` is high and the synchronized level is high. It reacts to `usb_en` in the same cycle, with no register in between.
- R4: After `reg_en` rises, `pwr_ready` goes high after exactly SETTLE clock edges of continuous enable. On that same edge the ready flag (0x124, bit 0) is set. The count restarts from zero whenever `reg_en` drops.
- R5: The status word at 0x438 holds the synchronized bus level in bit 0 and `pwr_ready` in bit 1. All other bits read 0.
- R6: A synchronized rising edge while `sys_off` is high gives a one-cycle `wake_req`, on the same edge that sets the attach flag. During that cycle `rst_cause` has bit 8 set and every other bit clear. Outside a wake request `rst_cause` is 0. With `sys_off` low there is no wake request.
- R7: Event flags are sticky. A write to a flag's address stores 0 if the write data is all zero and 1 otherwise. A hardware set in the same cycle wins over a software clear.
- R8: The enable-set address 0x304 sets, and the enable-clear address 0x308 clears, the enables marked by ones in the write data. The bits are 3 for attach, 4 for detach and 5 for ready. Both addresses read back the enable mask at those bits.
- R9: `irq` is high exactly when some flag is set and its enable is set.
- R10: `pwr_ready` and status bit 1 drop in the same cycle that `reg_en` drops. This happens when the bus level falls or when `usb_en` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vbus_in | input | 1 | Asynchronous bus-voltage-present level from the comparator |
| usb_en | input | 1 | USB peripheral enabled |
| sys_off | input | 1 | Chip is in its power-off state |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| reg_en | output | 1 | USB supply regulator enable |
| pwr_ready | output | 1 | Regulator output settled |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | One-cycle wake request to the reset controller |
| rst_cause | output | 9 | Reset-cause bits that go with the wake request |

## Verification
The assertions check several rules on every cycle. A synchronized edge always sets its flag on the next edge, and a hardware set is never lost. The ready output is never high while the regulator enable is low. The settling counter stays within its bound and finishes only after a full count. A wake request always comes with the attach flag. Other behaviour can only be shown by the directed scenarios. These include the exact edge count of the settling wait and its restart after an interrupted enable. They also include the two-edge synchronizer latency, the clash between a clear and a set in the same cycle, the interrupt mask read-back, and the absence of a wake while the chip is running.

// File: rtl/usbsup_pkg.sv
package usbsup_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int CAUSE_W  = 9;
    localparam int CAUSE_BUS_BIT = 8;

    localparam int IE_ATT_BIT = 3;
    localparam int IE_DET_BIT = 4;
    localparam int IE_RDY_BIT = 5;

    localparam logic [ADDR_W-1:0] A_EV_ATT  = 12'h11C;
    localparam logic [ADDR_W-1:0] A_EV_DET  = 12'h120;
    localparam logic [ADDR_W-1:0] A_EV_RDY  = 12'h124;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h304;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h308;
    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h438;

    // One bit per event source
    typedef struct packed {
        logic att;
        logic det;
        logic rdy;
    } usb_evt_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ATT,
        SEL_DET,
        SEL_RDY,
        SEL_ISET,
        SEL_ICLR,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            A_EV_ATT: s = SEL_ATT;
            A_EV_DET: s = SEL_DET;
            A_EV_RDY: s = SEL_RDY;
            A_IE_SET: s = SEL_ISET;
            A_IE_CLR: s = SEL_ICLR;
            A_STATUS: s = SEL_STAT;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/usbsup_sync.sv
module usbsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/usbsup_edge.sv
module usbsup_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_d;

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= lvl;
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/usbsup_settle.sv
module usbsup_settle #(
    parameter int SETTLE = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ready,
    output logic rdy_set
);
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);

    logic [CNT_W-1:0] cnt;
    logic             done;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == LAST) done <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign rdy_set = en && !done && (cnt == LAST);
    assign ready   = en && done;

    // R4: count never passes the last step
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST)
        else $error("p_cnt_bound_r4");

    // R4: completion only after a full enabled count
    p_done_full_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(cnt) == LAST) && $past(en))
        else $error("p_done_full_r4");
endmodule

// File: rtl/usbsup_regs.sv
module usbsup_regs
    import usbsup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  usb_evt_t          set_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stat_bus,
    input  logic              stat_rdy,
    output logic [DATA_W-1:0] rdata,
    output usb_evt_t          ev_q,
    output logic              irq
);
    reg_sel_e sel;
    usb_evt_t ie_q;
    logic     wval;
    logic [2:0] pend;

    assign sel  = decode_addr(addr);
    assign wval = |wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q <= '0;
        end else begin
            if (set_i.att)                  ev_q.att <= 1'b1;
            else if (wr_en && sel == SEL_ATT) ev_q.att <= wval;
            if (set_i.det)                  ev_q.det <= 1'b1;
            else if (wr_en && sel == SEL_DET) ev_q.det <= wval;
            if (set_i.rdy)                  ev_q.rdy <= 1'b1;
            else if (wr_en && sel == SEL_RDY) ev_q.rdy <= wval;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
        end else if (wr_en && sel == SEL_ISET) begin
            ie_q.att <= ie_q.att | wdata[IE_ATT_BIT];
            ie_q.det <= ie_q.det | wdata[IE_DET_BIT];
            ie_q.rdy <= ie_q.rdy | wdata[IE_RDY_BIT];
        end else if (wr_en && sel == SEL_ICLR) begin
            ie_q.att <= ie_q.att & ~wdata[IE_ATT_BIT];
            ie_q.det <= ie_q.det & ~wdata[IE_DET_BIT];
            ie_q.rdy <= ie_q.rdy & ~wdata[IE_RDY_BIT];
        end
    end

    assign pend = ev_q & ie_q;
    assign irq  = |pend;

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_ATT:  rdata[0] = ev_q.att;
            SEL_DET:  rdata[0] = ev_q.det;
            SEL_RDY:  rdata[0] = ev_q.rdy;
            SEL_ISET, SEL_ICLR: begin
                rdata[IE_ATT_BIT] = ie_q.att;
                rdata[IE_DET_BIT] = ie_q.det;
                rdata[IE_RDY_BIT] = ie_q.rdy;
            end
            SEL_STAT: begin
                rdata[0] = stat_bus;
                rdata[1] = stat_rdy;
            end
            default:  rdata = '0;
        endcase
    end

    // R2 / R7: a hardware set always lands, whatever software writes
    p_att_set_r2: assert property (@(posedge clk) disable iff (rst)
        set_i.att |=> ev_q.att)
        else $error("p_att_set_r2");
    p_det_set_r7: assert property (@(posedge clk) disable iff (rst)
        set_i.det |=> ev_q.det)
        else $error("p_det_set_r7");
    p_rdy_set_r4: assert property (@(posedge clk) disable iff (rst)
        set_i.rdy |=> ev_q.rdy)
        else $error("p_rdy_set_r4");

    // R8: an enable-set write with bit 3 turns the attach enable on
    p_ie_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_ISET && wdata[IE_ATT_BIT]) |=> ie_q.att)
        else $error("p_ie_set_r8");
endmodule

// File: rtl/usb_supply_seq.sv
module usb_supply_seq
    import usbsup_pkg::*;
#(
    parameter int SETTLE      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vbus_in,
    input  logic               usb_en,
    input  logic               sys_off,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               reg_en,
    output logic               pwr_ready,
    output logic               irq,
    output logic               wake_req,
    output logic [CAUSE_W-1:0] rst_cause
);
    localparam logic [CAUSE_W-1:0] CAUSE_BUS = CAUSE_W'(1) << CAUSE_BUS_BIT;

    logic     bus_s;
    logic     bus_rise;
    logic     bus_fall;
    logic     rdy_set;
    usb_evt_t set_v;
    usb_evt_t ev_q;

    usbsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (vbus_in),
        .q   (bus_s)
    );

    usbsup_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (bus_s),
        .rise (bus_rise),
        .fall (bus_fall)
    );

    assign reg_en = usb_en & bus_s;

    usbsup_settle #(.SETTLE(SETTLE)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .en      (reg_en),
        .ready   (pwr_ready),
        .rdy_set (rdy_set)
    );

    assign set_v.att = bus_rise;
    assign set_v.det = bus_fall;
    assign set_v.rdy = rdy_set;

    usbsup_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .set_i    (set_v),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .stat_bus (bus_s),
        .stat_rdy (pwr_ready),
        .rdata    (rdata),
        .ev_q     (ev_q),
        .irq      (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) wake_req <= 1'b0;
        else     wake_req <= bus_rise & sys_off;
    end

    assign rst_cause = wake_req ? CAUSE_BUS : '0;

    // R10: ready never outlives the regulator enable
    p_ready_gate_r10: assert property (@(posedge clk) disable iff (rst)
        !reg_en |-> !pwr_ready)
        else $error("p_ready_gate_r10");

    // R6: a wake request comes with the attach flag set
    p_wake_att_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> ev_q.att)
        else $error("p_wake_att_r6");

    // R6: wake requests are single-cycle pulses
    p_wake_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req)
        else $error("p_wake_pulse_r6");
endmodule

// File: tb/tb_usb_supply_seq.sv
`timescale 1ns/1ps
module tb_usb_supply_seq;
    localparam int SETTLE = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        vbus_in, usb_en, sys_off, wr_en;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        reg_en, pwr_ready, irq, wake_req;
    logic [8:0]  rst_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    usb_supply_seq #(.SETTLE(SETTLE)) dut (
        .clk(clk), .rst(rst), .vbus_in(vbus_in), .usb_en(usb_en),
        .sys_off(sys_off), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .reg_en(reg_en), .pwr_ready(pwr_ready), .irq(irq),
        .wake_req(wake_req), .rst_cause(rst_cause)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; write lands on the next posedge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h438, v); check("R5 status after reset", v, 0);
        rd(12'h11C, v); check("R2 attach flag after reset", v, 0);
        check("R3 reg_en after reset", {31'b0, reg_en}, 0);
        check("R9 irq after reset", {31'b0, irq}, 0);
    endtask

    task automatic t_attach();
        logic [31:0] v;
        vbus_in = 1'b1;
        step(1);
        rd(12'h438, v); check("R1 status bit0 after one edge", v, 0);
        step(1);
        rd(12'h438, v); check("R1 status bit0 after two edges", v, 1);
        rd(12'h11C, v); check("R2 attach flag not yet", v, 0);
        step(1);
        rd(12'h11C, v); check("R2 attach flag set", v, 1);
        check("R3 reg_en low with usb_en low", {31'b0, reg_en}, 0);
        check("R6 no wake while running", {31'b0, wake_req}, 0);
        check("R6 cause zero while running", {23'b0, rst_cause}, 0);
    endtask

    task automatic t_settle();
        logic [31:0] v;
        int n = 0;
        usb_en = 1'b1;
        #0.5;
        check("R3 reg_en follows usb_en same cycle", {31'b0, reg_en}, 1);
        while (!pwr_ready && n < SETTLE + 5) begin
            @(negedge clk); n++;
        end
        check("R4 settle edge count", n, SETTLE);
        rd(12'h124, v); check("R4 ready flag set", v, 1);
        rd(12'h438, v); check("R5 status bus+ready", v, 3);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        usb_en = 1'b0;
        #0.5;
        check("R10 ready drops with usb_en", {31'b0, pwr_ready}, 0);
        check("R3 reg_en drops with usb_en", {31'b0, reg_en}, 0);
        rd(12'h438, v); check("R10 status ready bit cleared", v, 1);
        wr(12'h124, 0);
        rd(12'h124, v); check("R7 software clear of ready flag", v, 0);
        usb_en = 1'b1;
        step(SETTLE - 1);
        check("R4 restarted count not done", {31'b0, pwr_ready}, 0);
        rd(12'h124, v); check("R4 ready flag not early", v, 0);
        step(1);
        check("R4 ready after full restart", {31'b0, pwr_ready}, 1);
    endtask

    task automatic t_detach();
        logic [31:0] v;
        wr(12'h11C, 0);
        vbus_in = 1'b0;
        step(1);
        check("R1 reg_en still on after one edge", {31'b0, reg_en}, 1);
        step(1);
        check("R3 reg_en off with bus gone", {31'b0, reg_en}, 0);
        check("R10 ready off with bus gone", {31'b0, pwr_ready}, 0);
        rd(12'h120, v); check("R2 detach flag not yet", v, 0);
        step(1);
        rd(12'h120, v); check("R2 detach flag set", v, 1);
        rd(12'h11C, v); check("R7 attach flag stays clear", v, 0);
    endtask

    task automatic t_wake();
        logic [31:0] v;
        sys_off = 1'b1;
        vbus_in = 1'b1;
        step(2);
        check("R6 no wake before edge", {31'b0, wake_req}, 0);
        step(1);
        check("R6 wake pulse", {31'b0, wake_req}, 1);
        check("R6 cause bit 8", {23'b0, rst_cause}, 32'h100);
        rd(12'h11C, v); check("R6 attach flag with wake", v, 1);
        step(1);
        check("R6 wake one cycle", {31'b0, wake_req}, 0);
        check("R6 cause cleared", {23'b0, rst_cause}, 0);
        sys_off = 1'b0;
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(12'h120, 0);
        rd(12'h120, v); check("R7 detach flag cleared", v, 0);
        vbus_in = 1'b0;
        step(2);
        wr(12'h120, 0);
        rd(12'h120, v); check("R7 hardware set wins over clear", v, 1);
        wr(12'h120, 0);
        rd(12'h120, v); check("R7 later clear works", v, 0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        usb_en = 1'b0;
        wr(12'h11C, 0); wr(12'h120, 0); wr(12'h124, 0);
        check("R9 irq idle", {31'b0, irq}, 0);
        wr(12'h304, 32'h08);
        rd(12'h304, v); check("R8 enable mask attach", v, 32'h08);
        wr(12'h120, 32'h5);
        rd(12'h120, v); check("R7 nonzero write sets flag", v, 1);
        check("R9 masked flag no irq", {31'b0, irq}, 0);
        wr(12'h304, 32'h10);
        check("R9 irq with detach enabled", {31'b0, irq}, 1);
        rd(12'h308, v); check("R8 mask via clear address", v, 32'h18);
        wr(12'h308, 32'h10);
        check("R9 irq off after disable", {31'b0, irq}, 0);
        rd(12'h304, v); check("R8 mask after clear", v, 32'h08);
        vbus_in = 1'b1;
        step(3);
        check("R9 irq on attach event", {31'b0, irq}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; vbus_in = 1'b0; usb_en = 1'b0; sys_off = 1'b0;
        wr_en = 1'b0; addr = '0; wdata = '0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_attach();
        t_settle();
        t_restart();
        t_detach();
        t_wake();
        t_collide();
        t_irq();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule